// File: doc/BRIEF.md
# Prefix Register-Select and Mode Sequencer

This block holds the control state that sits in front of a register-file datapath. It keeps a source index, a destination index and three one-shot mode flags: a move flag and two alternate-mode flags. Prefix opcodes change this state without finishing an instruction. The ordinary instruction that follows reads the state and then returns it to its defaults. Fetch, ALU and the register file are outside the block. It receives one already-decoded strobe per instruction: a class code and the low nibble of the opcode.

The two register-select classes have two meanings. While the move flag is clear they only pick an index. When the move flag was raised by a preceding "with" prefix, the same opcode instead becomes a complete register-to-register move. The block then emits a one-cycle move command carrying the source index, the destination index and whether the datapath must update its flags. Branches pass through without disturbing any pending prefix.

All outputs are registered and change on the clock edge that samples the strobe.

Top module: `prefix_seq`

## Requirements
- R1: A synchronous active-high `rst` forces sreg = 0, dreg = 0, b_flag = 0, alt1 = 0, alt2 = 0 and mv_valid = 0 on the next edge. It wins over a simultaneous strobe.
- R2: A strobe of class 2 (with) sets both sreg and dreg to op_nib and raises b_flag. alt1 and alt2 are unchanged.
- R3: A strobe of class 3 (alt prefix) clears b_flag. op_nib bit 0 sets alt1 and op_nib bit 1 sets alt2. A flag that is already set stays set, and the indices are unchanged.
- R4: A strobe of class 4 (to) with b_flag clear sets dreg to op_nib. All other state is unchanged and no move is issued.
- R5: A strobe of class 4 with b_flag set issues a move with mv_src = current sreg, mv_dst = op_nib and mv_flags = 0. The state then returns to its reset values.
- R6: A strobe of class 5 (from) with b_flag clear sets sreg to op_nib. All other state is unchanged and no move is issued.
- R7: A strobe of class 5 with b_flag set issues a move with mv_src = op_nib, mv_dst = current dreg and mv_flags = 1. The flag update is sign from bit 15, overflow from bit 7 and zero from the whole word. The state then returns to its reset values.
- R8: A strobe of class 0, 6 or 7 (ordinary instruction) returns the state to its reset values and issues no move.
- R9: A strobe of class 1 (branch) leaves sreg, dreg, b_flag, alt1 and alt2 unchanged and issues no move.
- R10: With op_valid low, the state holds and mv_valid is 0. mv_valid is high for exactly the one cycle after the strobe that caused it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One decoded instruction is presented this cycle |
| op_class | input | 3 | Decoded class: 0 ordinary, 1 branch, 2 with, 3 alt, 4 to, 5 from, 6/7 ordinary |
| op_nib | input | IDX_W | Opcode low nibble: register index, or alt bits |
| sreg | output | IDX_W | Current source register index |
| dreg | output | IDX_W | Current destination register index |
| b_flag | output | 1 | Move mode armed by a with prefix |
| alt1 | output | 1 | Alternate mode 1 |
| alt2 | output | 1 | Alternate mode 2 |
| mv_valid | output | 1 | One-cycle move command |
| mv_src | output | IDX_W | Move source index |
| mv_dst | output | IDX_W | Move destination index |
| mv_flags | output | 1 | Move must update sign/overflow/zero flags |

## Verification
Every result of this block is due exactly one clock edge after the strobe that causes it. This applies to the index and flag state, to the move command and to the state cleared by a completed instruction. The driver applies a strobe on a falling edge and queues the state the requirements predict. The monitor takes that item off the queue 1 ns after the next rising edge, so each comparison sees the first registered result of its own strobe. Runs of prefixes, branches between a prefix and its consumer, and reset arriving together with a strobe are driven as ordinary strobes, so the same one-edge timing covers them.

// File: rtl/psq_pkg.sv
package psq_pkg;
  localparam int CLS_W = 3;
  typedef enum logic [CLS_W-1:0] {
    CLS_PLAIN  = 3'd0,
    CLS_BRANCH = 3'd1,
    CLS_WITH   = 3'd2,
    CLS_ALT    = 3'd3,
    CLS_TO     = 3'd4,
    CLS_FROM   = 3'd5
  } op_class_e;

  typedef struct packed {
    logic hold;
    logic with_p;
    logic alt_p;
    logic set_d;
    logic set_s;
    logic mv_to;
    logic mv_from;
    logic clear;
  } act_t;
endpackage

// File: rtl/psq_decode.sv
module psq_decode
  import psq_pkg::*;
(
  input  logic             op_valid,
  input  logic [CLS_W-1:0] op_class,
  input  logic             b_now,
  output act_t             act
);
  always_comb begin
    act = '0;
    if (!op_valid) begin
      act.hold = 1'b1;
    end else begin
      case (op_class)
        CLS_BRANCH: act.hold   = 1'b1;
        CLS_WITH:   act.with_p = 1'b1;
        CLS_ALT:    act.alt_p  = 1'b1;
        CLS_TO: begin
          if (b_now) begin
            act.mv_to = 1'b1;
            act.clear = 1'b1;
          end else begin
            act.set_d = 1'b1;
          end
        end
        CLS_FROM: begin
          if (b_now) begin
            act.mv_from = 1'b1;
            act.clear   = 1'b1;
          end else begin
            act.set_s = 1'b1;
          end
        end
        default: act.clear = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/psq_state.sv
module psq_state
  import psq_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  act_t             act,
  input  logic [IDX_W-1:0] nib,
  output logic [IDX_W-1:0] sreg,
  output logic [IDX_W-1:0] dreg,
  output logic             b_flag,
  output logic             alt1,
  output logic             alt2
);
  always_ff @(posedge clk) begin
    if (rst || act.clear) begin
      sreg   <= '0;
      dreg   <= '0;
      b_flag <= 1'b0;
      alt1   <= 1'b0;
      alt2   <= 1'b0;
    end else begin
      if (act.with_p) begin
        sreg   <= nib;
        dreg   <= nib;
        b_flag <= 1'b1;
      end
      if (act.alt_p) begin
        b_flag <= 1'b0;
        alt1   <= alt1 | nib[0];
        alt2   <= alt2 | nib[1];
      end
      if (act.set_d) dreg <= nib;
      if (act.set_s) sreg <= nib;
    end
  end
endmodule

// File: rtl/psq_move.sv
module psq_move
  import psq_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  act_t             act,
  input  logic [IDX_W-1:0] nib,
  input  logic [IDX_W-1:0] sreg,
  input  logic [IDX_W-1:0] dreg,
  output logic             mv_valid,
  output logic [IDX_W-1:0] mv_src,
  output logic [IDX_W-1:0] mv_dst,
  output logic             mv_flags
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mv_valid <= 1'b0;
      mv_src   <= '0;
      mv_dst   <= '0;
      mv_flags <= 1'b0;
    end else begin
      mv_valid <= act.mv_to | act.mv_from;
      mv_flags <= act.mv_from;
      if (act.mv_to) begin
        mv_src <= sreg;
        mv_dst <= nib;
      end else if (act.mv_from) begin
        mv_src <= nib;
        mv_dst <= dreg;
      end
    end
  end
endmodule

// File: rtl/prefix_seq.sv
module prefix_seq
  import psq_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [2:0]       op_class,
  input  logic [IDX_W-1:0] op_nib,
  output logic [IDX_W-1:0] sreg,
  output logic [IDX_W-1:0] dreg,
  output logic             b_flag,
  output logic             alt1,
  output logic             alt2,
  output logic             mv_valid,
  output logic [IDX_W-1:0] mv_src,
  output logic [IDX_W-1:0] mv_dst,
  output logic             mv_flags
);
  act_t act;

  psq_decode u_dec (
    .op_valid (op_valid),
    .op_class (op_class),
    .b_now    (b_flag),
    .act      (act)
  );

  psq_state #(.IDX_W(IDX_W)) u_state (
    .clk    (clk),
    .rst    (rst),
    .act    (act),
    .nib    (op_nib),
    .sreg   (sreg),
    .dreg   (dreg),
    .b_flag (b_flag),
    .alt1   (alt1),
    .alt2   (alt2)
  );

  psq_move #(.IDX_W(IDX_W)) u_move (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .nib      (op_nib),
    .sreg     (sreg),
    .dreg     (dreg),
    .mv_valid (mv_valid),
    .mv_src   (mv_src),
    .mv_dst   (mv_dst),
    .mv_flags (mv_flags)
  );
endmodule

// File: rtl/prefix_seq_chk.sv
module prefix_seq_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic [2:0]       op_class,
  input logic [IDX_W-1:0] op_nib,
  input logic [IDX_W-1:0] sreg,
  input logic [IDX_W-1:0] dreg,
  input logic             b_flag,
  input logic             alt1,
  input logic             alt2,
  input logic             mv_valid,
  input logic [IDX_W-1:0] mv_src,
  input logic [IDX_W-1:0] mv_dst,
  input logic             mv_flags
);
  a_r1_reset_defaults: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sreg == '0 && dreg == '0 && !b_flag && !alt1 && !alt2 && !mv_valid));

  a_r2_with_selects: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_class == 3'd2) |=>
      (b_flag && sreg == $past(op_nib) && dreg == $past(op_nib) && !mv_valid));

  a_r5_to_move: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_class == 3'd4 && b_flag) |=>
      (mv_valid && !mv_flags && mv_dst == $past(op_nib) && mv_src == $past(sreg) && !b_flag));

  a_r7_from_move: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_class == 3'd5 && b_flag) |=>
      (mv_valid && mv_flags && mv_src == $past(op_nib) && mv_dst == $past(dreg) && !b_flag));

  a_r8_plain_clears: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_class == 3'd0) |=>
      (sreg == '0 && dreg == '0 && !b_flag && !alt1 && !alt2 && !mv_valid));

  a_r9_branch_keeps: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_class == 3'd1) |=>
      ($stable(sreg) && $stable(dreg) && $stable(b_flag) && $stable(alt1) && $stable(alt2) && !mv_valid));

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=>
      ($stable(sreg) && $stable(dreg) && $stable(b_flag) && $stable(alt1) && $stable(alt2) && !mv_valid));
endmodule

bind prefix_seq prefix_seq_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_prefix_seq.sv
`timescale 1ns/1ps
module tb_prefix_seq;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [2:0] op_class = 3'd0;
  logic [W-1:0] op_nib = '0;
  logic [W-1:0] sreg, dreg, mv_src, mv_dst;
  logic b_flag, alt1, alt2, mv_valid, mv_flags;

  always #2.5 clk = ~clk;

  prefix_seq #(.IDX_W(W)) dut (.*);

  typedef struct {
    string        tag;
    logic [W-1:0] s, d, src, dst;
    logic         b, a1, a2, mv, fl;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [W-1:0] m_s = '0, m_d = '0;
  logic m_b = 0, m_a1 = 0, m_a2 = 0;

  task automatic drive(input logic r, input logic v, input logic [2:0] c,
                       input logic [W-1:0] n, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; op_valid = v; op_class = c; op_nib = n;
    e.tag = tag; e.mv = 0; e.fl = 0; e.src = 'x; e.dst = 'x;
    if (r) begin
      m_s = 0; m_d = 0; m_b = 0; m_a1 = 0; m_a2 = 0;
    end else if (v) begin
      case (c)
        3'd1: ;
        3'd2: begin m_s = n; m_d = n; m_b = 1; end
        3'd3: begin m_b = 0; m_a1 = m_a1 | n[0]; m_a2 = m_a2 | n[1]; end
        3'd4: if (m_b) begin
                e.mv = 1; e.src = m_s; e.dst = n;
                m_s = 0; m_d = 0; m_b = 0; m_a1 = 0; m_a2 = 0;
              end else m_d = n;
        3'd5: if (m_b) begin
                e.mv = 1; e.fl = 1; e.src = n; e.dst = m_d;
                m_s = 0; m_d = 0; m_b = 0; m_a1 = 0; m_a2 = 0;
              end else m_s = n;
        default: begin m_s = 0; m_d = 0; m_b = 0; m_a1 = 0; m_a2 = 0; end
      endcase
    end
    e.s = m_s; e.d = m_d; e.b = m_b; e.a1 = m_a1; e.a2 = m_a2;
    q.push_back(e);
  endtask

  // monitor: results are due on the first rising edge after the strobe
  always @(posedge clk) begin
    exp_t e;
    bit bad;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      bad = (sreg !== e.s) || (dreg !== e.d) || (b_flag !== e.b) ||
            (alt1 !== e.a1) || (alt2 !== e.a2) || (mv_valid !== e.mv);
      if (e.mv) bad = bad || (mv_src !== e.src) || (mv_dst !== e.dst) || (mv_flags !== e.fl);
      if (bad) begin
        failures++;
        $display("FAIL %s got s=%0d d=%0d b=%b a=%b%b mv=%b src=%0d dst=%0d f=%b exp s=%0d d=%0d b=%b a=%b%b mv=%b src=%0d dst=%0d f=%b",
                 e.tag, sreg, dreg, b_flag, alt1, alt2, mv_valid, mv_src, mv_dst, mv_flags,
                 e.s, e.d, e.b, e.a1, e.a2, e.mv, e.src, e.dst, e.fl);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    drive(1, 1, 3'd2, 4'd9, "R1 reset with strobe");
    drive(1, 0, 3'd0, 4'd0, "R1 reset held");
    drive(0, 0, 3'd2, 4'd5, "R10 idle after reset");
    drive(0, 1, 3'd5, 4'd3, "R6 from sets sreg");
    drive(0, 1, 3'd4, 4'd5, "R4 to sets dreg");
    drive(0, 0, 3'd0, 4'd0, "R10 idle holds");
    drive(0, 1, 3'd0, 4'd0, "R8 plain clears");
    drive(0, 1, 3'd2, 4'd7, "R2 with");
    drive(0, 1, 3'd4, 4'd9, "R5 to as move");
    drive(0, 0, 3'd0, 4'd0, "R10 move one cycle");
    drive(0, 1, 3'd3, 4'd2, "R3 alt2 only");
    drive(0, 1, 3'd2, 4'd2, "R2 with keeps alt");
    drive(0, 1, 3'd3, 4'd1, "R3 alt1 clears b");
    drive(0, 1, 3'd4, 4'd4, "R4 to with b cleared");
    drive(0, 1, 3'd1, 4'd8, "R9 branch keeps");
    drive(0, 1, 3'd6, 4'd0, "R8 class 6 clears");
    drive(0, 1, 3'd2, 4'd3, "R2 with 3");
    drive(0, 1, 3'd5, 4'd11, "R7 from as move");
    drive(0, 1, 3'd2, 4'd5, "R2 with 5");
    drive(0, 1, 3'd1, 4'd0, "R9 branch keeps b");
    drive(0, 1, 3'd4, 4'd1, "R5 move after branch");
    drive(0, 1, 3'd2, 4'd4, "R2 with 4");
    drive(0, 1, 3'd3, 4'd3, "R3 alt both");
    drive(0, 1, 3'd3, 4'd0, "R3 alt none keeps");
    drive(0, 1, 3'd7, 4'd15, "R8 class 7 clears");
    drive(0, 1, 3'd2, 4'd6, "R2 with 6");
    drive(1, 1, 3'd5, 4'd2, "R1 reset beats move");
    for (int i = 0; i < 16; i++) begin
      drive(0, 1, 3'd2, 4'(i), "R2 with sweep");
      drive(0, 1, 3'd5, 4'(15 - i), "R7 from sweep");
      drive(0, 1, 3'd5, 4'(i), "R6 from sweep");
      drive(0, 1, 3'd4, 4'(15 - i), "R4 to sweep");
    end
    repeat (3) drive(0, 0, 3'd0, 4'd0, "R10 final idle");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule